// File: doc/BRIEF.md
# Compare-Clear Interval Timer

This block is a 16-bit up-counter that runs from a power-of-two prescaled clock and wraps back to zero when it reaches a programmable compare value. Each wrap sets a sticky event flag. When the flag and an enable bit are both set, the block raises an interrupt request. Software drives the block over a byte-wide register bus with four addresses. From the same bus it can zero the counter, stop and start it, choose the prescale ratio and acknowledge the flag.

The counter can also be forced to zero by one of two external single-cycle events, named write-timing and position-detect. A mode bit picks which of the two is used, and the other one is ignored. The 16-bit compare value is loaded one byte at a time. The upper byte waits in a holding register. Both bytes are committed together when the lower byte is written, so the comparator never sees a half-written value.

Top module: `cmp_clear_timer`

## Requirements
- R1: After reset, the control register (address 0) reads 0x00, `count_o` is 0, `irq_o` is 0, and the compare value is 0xFFFF, so addresses 1 and 2 both read 0xFF.
- R2: Writing address 0 with bit 7 set zeroes the counter and the prescaler on that edge. Writing bit 7 as 0 leaves the count unchanged. Bit 7 always reads as 0.
- R3: While control bit 6 is 0, a pulse on `evt_write` zeroes the counter and `evt_pos` is ignored. While bit 6 is 1, the roles of the two inputs are swapped.
- R4: On a tick where the count equals the compare value, the counter returns to 0 and the flag (control bit 5) becomes 1. After a clear-and-start write, the first wrap happens (cmp+1)·2^n cycles after the write edge.
- R5: `irq_o` is 1 exactly when the flag and the interrupt enable (control bit 4) are both 1.
- R6: Writing control bit 5 as 0 clears the flag. Writing it as 1 leaves the flag unchanged.
- R7: A read with `bus_rmw` high returns bit 5 of the control register as 1, whatever the flag holds. A plain read returns the true flag.
- R8: If a wrap and a write that clears the flag land on the same edge, the flag ends at 1.
- R9: The counter advances only while the run enable (control bit 3) is 1. Otherwise it holds its value.
- R10: With control bits 2:0 equal to n, the counter advances once every 2^n clock cycles.
- R11: A write to address 1 only loads the holding register, and address 1 reads back the held byte. A write to address 2 commits {held byte, written byte} as the new compare value, and address 2 reads back the committed lower byte.
- R12: A software clear or an external reset takes priority over counting and over a wrap on the same edge, and never sets the flag.
- R13: `bus_rdata` is registered. It shows the addressed register on the cycle after `bus_rd` is sampled high, and address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address: 0 control, 1 compare upper, 2 compare lower |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rmw | input | 1 | Marks the read as the read half of a read-modify-write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| evt_write | input | 1 | Write-timing reset event, one cycle wide |
| evt_pos | input | 1 | Position-detect reset event, one cycle wide |
| irq_o | output | 1 | Interrupt request |
| count_o | output | 16 | Current counter value |

## Verification
The properties assume that the bus never asserts `bus_wr` and `bus_rd` in the same cycle, that every strobe and every external event lasts a single clock, and that all three inputs are 0 or 1, never unknown, once reset has been released. The stimulus tasks drive one transaction at a time on the falling edge and release it on the next falling edge. External events are issued by their own task, which raises one pulse at a time. Each scenario places its wraps, clears and events on edges it has counted, so that coincidences such as a wrap meeting a flag clear happen on purpose and nowhere else.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int CSEL_W = 3;
  localparam int DIV_W  = (1 << CSEL_W) - 1;

  typedef enum logic [1:0] {
    A_CTRL   = 2'd0,
    A_CMP_HI = 2'd1,
    A_CMP_LO = 2'd2,
    A_SPARE  = 2'd3
  } reg_addr_e;

  localparam int B_CLR  = 7;
  localparam int B_MODE = 6;
  localparam int B_FLAG = 5;
  localparam int B_IE   = 4;
  localparam int B_EN   = 3;
endpackage

// File: rtl/cct_prescale.sv
module cct_prescale
  import cct_pkg::*;
#(
  parameter int SEL_W = CSEL_W,
  localparam int DW   = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             sync_clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [DW-1:0] div_q;
  logic [DW-1:0] mask;

  // Low n bits set: a tick fires when the low n bits of the divider are all ones
  always_comb begin
    mask = '0;
    for (int k = 0; k < DW; k++) begin
      if (k < int'(sel)) mask[k] = 1'b1;
    end
  end

  assign tick = run && ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || !run || sync_clr) div_q <= '0;
    else                         div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/cct_core.sv
module cct_core
  import cct_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         tick,
  input  logic         cnt_rst,
  input  logic [W-1:0] cmp,
  output logic [W-1:0] count,
  output logic         hit
);
  logic at_cmp;
  assign at_cmp = (count == cmp);
  assign hit    = run && tick && at_cmp && !cnt_rst;

  always_ff @(posedge clk) begin
    if (rst)                count <= '0;
    else if (cnt_rst)       count <= '0;
    else if (hit)           count <= '0;
    else if (run && tick)   count <= count + 1'b1;
  end
endmodule

// File: rtl/cct_regs.sv
module cct_regs
  import cct_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        addr,
  input  logic              wr,
  input  logic              rd,
  input  logic              rmw,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              hit,
  output logic [BYTE_W-1:0] rdata,
  output logic              mode_q,
  output logic              ie_q,
  output logic              en_q,
  output logic [CSEL_W-1:0] csel_q,
  output logic              flag_q,
  output logic              irq_q,
  output logic              sw_clr,
  output logic [CNT_W-1:0]  cmp_q
);
  localparam int HI_W = CNT_W - BYTE_W;

  logic              ctrl_wr;
  logic              flag_n;
  logic              ie_n;
  logic [HI_W-1:0]   hold_q;
  logic [BYTE_W-1:0] rd_mux;

  assign ctrl_wr = wr && (addr == A_CTRL);
  assign sw_clr  = ctrl_wr && wdata[B_CLR];

  // Hardware set outranks a software acknowledge on the same edge
  always_comb begin
    flag_n = flag_q;
    if (hit)                          flag_n = 1'b1;
    else if (ctrl_wr && !wdata[B_FLAG]) flag_n = 1'b0;
    ie_n = ctrl_wr ? wdata[B_IE] : ie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      ie_q   <= 1'b0;
      en_q   <= 1'b0;
      csel_q <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        mode_q <= wdata[B_MODE];
        en_q   <= wdata[B_EN];
        csel_q <= wdata[CSEL_W-1:0];
      end
      ie_q   <= ie_n;
      flag_q <= flag_n;
      irq_q  <= flag_n && ie_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '1;
      cmp_q  <= '1;
    end else if (wr && addr == A_CMP_HI) begin
      hold_q <= wdata[HI_W-1:0];
    end else if (wr && addr == A_CMP_LO) begin
      cmp_q  <= {hold_q, wdata};
    end
  end

  always_comb begin
    unique case (reg_addr_e'(addr))
      A_CTRL:   rd_mux = {1'b0, mode_q, (rmw | flag_q), ie_q, en_q, csel_q};
      A_CMP_HI: rd_mux = hold_q[BYTE_W-1:0];
      A_CMP_LO: rd_mux = cmp_q[BYTE_W-1:0];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end
endmodule

// File: rtl/cmp_clear_timer.sv
module cmp_clear_timer
  import cct_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_rmw,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              evt_write,
  input  logic              evt_pos,
  output logic              irq_o,
  output logic [CNT_W-1:0]  count_o
);
  logic              mode_q, ie_q, en_q, flag_q, sw_clr, hit, tick, cnt_rst, ext_rst;
  logic [CSEL_W-1:0] csel_q;
  logic [CNT_W-1:0]  cmp_q;

  assign ext_rst = mode_q ? evt_pos : evt_write;
  assign cnt_rst = sw_clr || ext_rst;

  cct_regs u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .rmw(bus_rmw), .wdata(bus_wdata), .hit(hit), .rdata(bus_rdata),
    .mode_q(mode_q), .ie_q(ie_q), .en_q(en_q), .csel_q(csel_q),
    .flag_q(flag_q), .irq_q(irq_o), .sw_clr(sw_clr), .cmp_q(cmp_q)
  );

  cct_prescale #(.SEL_W(CSEL_W)) u_pre (
    .clk(clk), .rst(rst), .run(en_q), .sync_clr(cnt_rst),
    .sel(csel_q), .tick(tick)
  );

  cct_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .run(en_q), .tick(tick), .cnt_rst(cnt_rst),
    .cmp(cmp_q), .count(count_o), .hit(hit)
  );
endmodule

// File: rtl/cct_checker.sv
module cct_checker
  import cct_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [1:0]        bus_addr,
  input logic              bus_wr,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic              evt_write,
  input logic              evt_pos,
  input logic              mode_q,
  input logic              en_q,
  input logic              ie_q,
  input logic              flag_q,
  input logic              hit,
  input logic              irq_o,
  input logic [CNT_W-1:0]  count_o
);
  logic ctl_wr, ext_sel;
  assign ctl_wr  = bus_wr && (bus_addr == 2'd0);
  assign ext_sel = mode_q ? evt_pos : evt_write;

  p_sw_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && bus_wdata[7]) |=> (count_o == '0));

  p_ext_reset_r3: assert property (@(posedge clk) disable iff (rst)
    ext_sel |=> (count_o == '0));

  p_wrap_flag_r4: assert property (@(posedge clk) disable iff (rst)
    hit |=> (flag_q && count_o == '0));

  p_irq_gate_r5: assert property (@(posedge clk) disable iff (rst)
    irq_o == (flag_q && ie_q));

  p_flag_ack_r6: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !bus_wdata[5] && !hit) |=> !flag_q);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (hit && ctl_wr && !bus_wdata[5]) |=> flag_q);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !ext_sel && !(ctl_wr && bus_wdata[7])) |=> $stable(count_o));

  p_reset_no_flag_r12: assert property (@(posedge clk) disable iff (rst)
    ((ext_sel || (ctl_wr && bus_wdata[7])) && !flag_q) |=> !flag_q);
endmodule

bind cmp_clear_timer cct_checker chk_i (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .evt_write(evt_write), .evt_pos(evt_pos),
  .mode_q(mode_q), .en_q(en_q), .ie_q(ie_q), .flag_q(flag_q),
  .hit(hit), .irq_o(irq_o), .count_o(count_o)
);

// File: tb/cmp_clear_timer_tb_top.sv
`timescale 1ns/1ps
module cmp_clear_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_rmw = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       evt_write = 1'b0, evt_pos = 1'b0;
  logic       irq_o;
  logic [15:0] count_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  cmp_clear_timer dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_rmw(bus_rmw), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .evt_write(evt_write), .evt_pos(evt_pos),
    .irq_o(irq_o), .count_o(count_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog R4 actual=%0d expected=finish", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input bit rmw, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1; bus_rmw = rmw;
    @(posedge clk); @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0; bus_rmw = 1'b0;
  endtask

  task automatic pulse(input bit pos);
    if (pos) evt_pos = 1'b1; else evt_write = 1'b1;
    @(posedge clk); @(negedge clk);
    evt_pos = 1'b0; evt_write = 1'b0;
  endtask

  task automatic stop();
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h00);
  endtask

  task automatic set_cmp(input int v);
    wr(2'd1, v[15:8]);
    wr(2'd2, v[7:0]);
  endtask

  task automatic run_period(input int n, input int cmpv, input string req, input bit trace);
    int lim = (cmpv + 1) << n;
    int first = -1;
    int bad = 0;
    int badv = 0;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (trace && int'(count_o) != ((i >> n) % (cmpv + 1))) begin
        bad++;
        badv = i;
      end
      if (irq_o && first < 0) first = i;
    end
    chk(first == lim, req, first, lim);
    if (trace) chk(bad == 0, "R10 count trace", badv, 0);
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 / R13 reset values
    chk(count_o == 0 && irq_o == 0, "R1 count/irq", {count_o, 7'b0, irq_o}, 0);
    rd(2'd0, 1'b0, d); chk(d == 8'h00, "R1 ctrl", d, 8'h00);
    rd(2'd1, 1'b0, d); chk(d == 8'hFF, "R1 cmp hi", d, 8'hFF);
    rd(2'd2, 1'b0, d); chk(d == 8'hFF, "R1 cmp lo", d, 8'hFF);
    rd(2'd3, 1'b0, d); chk(d == 8'h00, "R13 spare", d, 8'h00);

    // R4 R10 R5 sweep of prescale and compare
    for (int n = 0; n < 4; n++) begin
      for (int c = 0; c < 7; c++) begin
        stop();
        set_cmp(c);
        wr(2'd0, 8'h98 | n[7:0]);
        run_period(n, c, "R4 period", 1'b1);
      end
    end

    // R7 read-modify-write view of the flag
    stop();
    rd(2'd0, 1'b0, d); chk(d == 8'h00, "R7 plain read", d, 8'h00);
    rd(2'd0, 1'b1, d); chk(d == 8'h20, "R7 rmw read", d, 8'h20);

    // R6 writing 1 does not set; R5 gating; R6 writing 0 clears
    wr(2'd0, 8'h20);
    rd(2'd0, 1'b0, d); chk(d == 8'h00, "R6 write1 no set", d, 8'h00);
    set_cmp(1);
    wr(2'd0, 8'h88);
    @(negedge clk); @(negedge clk);
    chk(irq_o == 1'b0, "R5 irq masked", irq_o, 0);
    wr(2'd0, 8'h20);
    rd(2'd0, 1'b0, d); chk(d == 8'h20, "R6 write1 keeps", d, 8'h20);
    wr(2'd0, 8'h30);
    chk(irq_o == 1'b1, "R5 irq on", irq_o, 1);
    wr(2'd0, 8'h10);
    chk(irq_o == 1'b0, "R6 ack irq", irq_o, 0);
    rd(2'd0, 1'b0, d); chk(d == 8'h10, "R6 ack flag", d, 8'h10);

    // R9 hold when stopped, R2 zero write no effect, R2 clear
    stop();
    set_cmp(100);
    wr(2'd0, 8'h88);
    repeat (5) @(negedge clk);
    wr(2'd0, 8'h00);
    repeat (10) @(negedge clk);
    chk(count_o == 6, "R9 hold", count_o, 6);
    wr(2'd0, 8'h00);
    chk(count_o == 6, "R2 bit7 zero", count_o, 6);
    wr(2'd0, 8'h80);
    chk(count_o == 0, "R2 clear", count_o, 0);
    rd(2'd0, 1'b0, d); chk(d == 8'h00, "R2 reads 0", d, 8'h00);

    // R3 event selection by mode bit
    set_cmp(200);
    wr(2'd0, 8'h88);
    repeat (4) @(negedge clk);
    pulse(1'b1);
    chk(count_o == 5, "R3 pos ignored", count_o, 5);
    pulse(1'b0);
    chk(count_o == 0, "R3 write evt", count_o, 0);
    wr(2'd0, 8'hC8);
    repeat (4) @(negedge clk);
    pulse(1'b0);
    chk(count_o == 5, "R3 write ignored", count_o, 5);
    pulse(1'b1);
    chk(count_o == 0, "R3 pos evt", count_o, 0);

    // R8 wrap meets acknowledge
    stop();
    set_cmp(3);
    wr(2'd0, 8'h98);
    repeat (3) @(negedge clk);
    wr(2'd0, 8'h18);
    chk(irq_o == 1'b1, "R8 set wins", irq_o, 1);
    rd(2'd0, 1'b0, d); chk(d == 8'h38, "R8 flag", d, 8'h38);

    // R12 external reset on the wrap edge
    stop();
    wr(2'd0, 8'h98);
    repeat (3) @(negedge clk);
    pulse(1'b0);
    chk(count_o == 0 && irq_o == 0, "R12 reset no flag", {count_o, 7'b0, irq_o}, 0);
    repeat (2) @(negedge clk);
    chk(count_o == 2, "R12 resumes", count_o, 2);

    // R11 staged compare value
    stop();
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h02);
    wr(2'd1, 8'h01);
    rd(2'd1, 1'b0, d); chk(d == 8'h01, "R11 held hi", d, 8'h01);
    rd(2'd2, 1'b0, d); chk(d == 8'h02, "R11 lo", d, 8'h02);
    wr(2'd0, 8'h98);
    run_period(0, 2, "R11 not committed", 1'b0);
    stop();
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h98);
    run_period(0, 256, "R11 committed", 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule